// File: doc/BRIEF.md
# Power-Fail Gated SRAM Bus Front-End

This block connects an asynchronous-style static memory bus (active-low chip enable, output enable and write enable, 17-bit address, 8-bit data) to an internal byte array. It runs on a system clock and samples the bus strobes every cycle. A bus state machine turns the strobes into array write strobes and a tri-state enable for the data pins. The data pins themselves are modelled as a separate input bus, output bus and enable.

A second state machine watches three digital supply flags from external comparators: supply above the upper deselect threshold, supply above the lower deselect threshold, and supply above the battery switchover threshold. Each flag passes through a two-flop synchronizer. When the supply falls out of the window, the bus is deselected and write protected. When the supply returns, deselect is held for a recovery time. That time is counted in ticks from a one-cycle millisecond strobe and set by a port that is clamped to 40..200 ms. A battery-select output follows the switchover flag on its own path.

Supply states: SUP_OFF (deselected), SUP_RECOVER (deselected, counting ticks), SUP_ON (bus usable). The supply transitions are:
- OFF to RECOVER when both window flags are high.
- RECOVER to ON on the tick that completes the count.
- RECOVER to OFF or ON to OFF when the lower flag drops.
- The counter clears, while the state stays in RECOVER, when the upper flag drops during recovery.

Bus states: BUS_IDLE, BUS_READ, BUS_WRITE, BUS_BLOCK. The bus transitions are:
- Any state goes to BLOCK when deselect is active.
- BLOCK goes to IDLE once chip enable is seen high.
- From IDLE, READ or WRITE, the next state is picked from the strobes: write when chip enable and write enable are both low, read when chip enable and output enable are low with write enable high, idle otherwise.

Top module: `pfg_sram_front`

## Requirements
- R1: With deselect low, ce_n=0 and we_n=0 sampled at a clock edge give arr_we=1 after that edge. arr_addr and arr_wdata then carry the sampled bus_addr and bus_din. A write therefore spans only the cycles in which both strobes are low.
- R2: With deselect low, ce_n=0, we_n=1 and oe_n=0 sampled at an edge give bus_drive=1 after it, with bus_dout equal to arr_rdata. Any other strobe combination gives bus_drive=0 and bus_dout=0.
- R3: A low we_n sampled at an edge forces bus_drive=0 after that edge. This holds when the bus was reading, and when ce_n and we_n fall together with oe_n low, in which case bus_drive never goes to 1.
- R4: While deselect is 1, bus_drive and arr_we stay 0 whatever the bus strobes do, and wr_protect equals 1.
- R5: A lower-threshold flag dropping to 0 raises deselect on the third clock edge. A write in progress has arr_we=0 in the same cycle that deselect rises.
- R6: bat_sel is the inverse of the battery flag, delayed by three clock edges (two synchronizer flops and one output flop).
- R7: After both window flags are 1, deselect stays 1 until the limit-th ms_tick counted in recovery. It falls after that tick.
- R8: If the upper flag drops to 0 during recovery while the lower flag stays 1, the tick count restarts from zero.
- R9: The recovery limit is rec_ms clamped to the range 40..200. Values below 40 act as 40 and values above 200 act as 200.
- R10: After deselect falls, no read or write is accepted until ce_n has been sampled high at least once.
- R11: After reset, deselect=1, wr_protect=1, bat_sel=1, bus_drive=0, arr_we=0.
- R12: Once in SUP_ON, a drop of only the upper flag (lower flag still 1) leaves deselect at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rec_ms | input | 8 | Requested recovery time in ms, clamped to 40..200 |
| sup_hi_raw | input | 1 | Supply above upper deselect threshold (asynchronous) |
| sup_lo_raw | input | 1 | Supply above lower deselect threshold (asynchronous) |
| sup_bat_raw | input | 1 | Supply above battery switchover threshold (asynchronous) |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 17 | Byte address |
| bus_din | input | 8 | Data pins, input side |
| bus_dout | output | 8 | Data pins, output side |
| bus_drive | output | 1 | Tri-state enable for the data pins |
| arr_addr | output | 17 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write strobe |
| arr_rdata | input | 8 | Array read data |
| deselect | output | 1 | Bus deselected by supply state |
| wr_protect | output | 1 | Writes blocked by supply state |
| bat_sel | output | 1 | Select battery power |

## Verification
The bus decoder is exercised with each strobe combination. The cases include chip-enable-led and write-enable-led writes, which separate the "later fall starts, earlier rise ends" rule from a decoder that looks at one strobe only. They also include a read interrupted by write enable and a simultaneous chip/write enable fall, which together expose any path that lets the outputs turn on during a write. The supply machine is driven through power-up with exact tick counts at limit-1 and limit, a dip below the upper flag in mid-recovery, and requested times below, inside and above the legal range. These cases separate an off-by-one counter, a missing restart and a missing clamp. A strobe held low across the release of deselect shows whether a half-seen access could leak through. Dropping the power during a write shows whether the array strobe is cut in the same cycle as deselect.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        SUP_OFF     = 2'd0,
        SUP_RECOVER = 2'd1,
        SUP_ON      = 2'd2
    } sup_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2,
        BUS_BLOCK = 2'd3
    } bus_state_t;

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1_q;
        logic stage2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= d_async[i];
                stage2_q <= stage1_q;
            end
        end

        assign q_sync[i] = stage2_q;
    end

endmodule

// File: rtl/pfg_supply_fsm.sv
module pfg_supply_fsm
    import pfg_pkg::*;
#(
    parameter int REC_W   = 8,
    parameter int REC_MIN = 40,
    parameter int REC_MAX = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_ok,
    input  logic             lo_ok,
    input  logic             ms_tick,
    input  logic [REC_W-1:0] rec_ms,
    output logic             desel,
    output logic             wprot
);

    localparam logic [REC_W-1:0] LIM_LO = REC_W'(REC_MIN);
    localparam logic [REC_W-1:0] LIM_HI = REC_W'(REC_MAX);

    sup_state_t       state_q, state_d;
    logic [REC_W-1:0] cnt_q;
    logic [REC_W-1:0] limit;
    logic             last_tick;

    always_comb begin
        if (rec_ms < LIM_LO)      limit = LIM_LO;
        else if (rec_ms > LIM_HI) limit = LIM_HI;
        else                      limit = rec_ms;
    end

    assign last_tick = hi_ok && ms_tick && (cnt_q == limit - REC_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_OFF: begin
                if (lo_ok && hi_ok) state_d = SUP_RECOVER;
            end
            SUP_RECOVER: begin
                if (!lo_ok)         state_d = SUP_OFF;
                else if (last_tick) state_d = SUP_ON;
            end
            SUP_ON: begin
                if (!lo_ok) state_d = SUP_OFF;
            end
            default: state_d = SUP_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SUP_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == SUP_RECOVER) begin
            if (!hi_ok)       cnt_q <= '0;
            else if (ms_tick) cnt_q <= cnt_q + REC_W'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        unique case (state_q)
            SUP_ON: begin
                desel = 1'b0;
                wprot = 1'b0;
            end
            default: begin
                desel = 1'b1;
                wprot = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pfg_bus_fsm.sv
module pfg_bus_fsm
    import pfg_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr_out,
    output logic [DW-1:0] wdata_out,
    output logic          we_out,
    output logic          drive,
    output logic [DW-1:0] dout
);

    bus_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    bus_state_t    decoded;

    always_comb begin
        if (!ce_n && !we_n)      decoded = BUS_WRITE;
        else if (!ce_n && !oe_n) decoded = BUS_READ;
        else                     decoded = BUS_IDLE;
    end

    always_comb begin
        state_d = state_q;
        if (block) begin
            state_d = BUS_BLOCK;
        end else begin
            unique case (state_q)
                BUS_BLOCK: state_d = ce_n ? BUS_IDLE : BUS_BLOCK;
                BUS_IDLE,
                BUS_READ,
                BUS_WRITE: state_d = decoded;
                default:   state_d = BUS_BLOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_BLOCK;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (!block) begin
            addr_q <= addr_in;
            data_q <= din;
        end
    end

    always_comb begin
        we_out = 1'b0;
        drive  = 1'b0;
        unique case (state_q)
            BUS_WRITE: we_out = !block;
            BUS_READ:  drive  = !block;
            default: ;
        endcase
    end

    assign addr_out  = addr_q;
    assign wdata_out = data_q;
    assign dout      = drive ? rdata : '0;

endmodule

// File: rtl/pfg_sram_front.sv
module pfg_sram_front #(
    parameter int AW      = 17,
    parameter int DW      = 8,
    parameter int REC_W   = 8,
    parameter int REC_MIN = 40,
    parameter int REC_MAX = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [REC_W-1:0] rec_ms,
    input  logic             sup_hi_raw,
    input  logic             sup_lo_raw,
    input  logic             sup_bat_raw,
    input  logic             bus_ce_n,
    input  logic             bus_oe_n,
    input  logic             bus_we_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_din,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_drive,
    output logic [AW-1:0]    arr_addr,
    output logic [DW-1:0]    arr_wdata,
    output logic             arr_we,
    input  logic [DW-1:0]    arr_rdata,
    output logic             deselect,
    output logic             wr_protect,
    output logic             bat_sel
);

    localparam int NFLAG = 3;
    localparam int F_HI  = 0;
    localparam int F_LO  = 1;
    localparam int F_BAT = 2;

    logic [NFLAG-1:0] flags_s;
    logic             desel_w;
    logic             wprot_w;
    logic             bat_q;

    pfg_sync #(.W(NFLAG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sup_bat_raw, sup_lo_raw, sup_hi_raw}),
        .q_sync  (flags_s)
    );

    pfg_supply_fsm #(
        .REC_W   (REC_W),
        .REC_MIN (REC_MIN),
        .REC_MAX (REC_MAX)
    ) u_supply (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_ok   (flags_s[F_HI]),
        .lo_ok   (flags_s[F_LO]),
        .ms_tick (ms_tick),
        .rec_ms  (rec_ms),
        .desel   (desel_w),
        .wprot   (wprot_w)
    );

    pfg_bus_fsm #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .block     (desel_w),
        .ce_n      (bus_ce_n),
        .oe_n      (bus_oe_n),
        .we_n      (bus_we_n),
        .addr_in   (bus_addr),
        .din       (bus_din),
        .rdata     (arr_rdata),
        .addr_out  (arr_addr),
        .wdata_out (arr_wdata),
        .we_out    (arr_we),
        .drive     (bus_drive),
        .dout      (bus_dout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bat_q <= 1'b1;
        else        bat_q <= !flags_s[F_BAT];
    end

    assign deselect   = desel_w;
    assign wr_protect = wprot_w;
    assign bat_sel    = bat_q;

endmodule

// File: rtl/pfg_sram_front_chk.sv
module pfg_sram_front_chk (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic sup_bat_raw,
    input logic bus_ce_n,
    input logic bus_oe_n,
    input logic bus_we_n,
    input logic bus_drive,
    input logic arr_we,
    input logic deselect,
    input logic wr_protect,
    input logic bat_sel
);

    a_r4_desel_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        deselect |-> (!bus_drive && !arr_we && wr_protect));

    a_r3_we_low_kills_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |=> !bus_drive);

    a_r1_write_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(!bus_ce_n && !bus_we_n));

    a_r2_drive_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> $past(!bus_ce_n && !bus_oe_n && bus_we_n));

    a_r6_bat_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_sel) |-> !$past(sup_bat_raw, 3));

    a_r6_bat_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bat_sel) |-> $past(sup_bat_raw, 3));

    a_r7_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(deselect) |-> $past(ms_tick));

endmodule

bind pfg_sram_front pfg_sram_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .sup_bat_raw (sup_bat_raw),
    .bus_ce_n    (bus_ce_n),
    .bus_oe_n    (bus_oe_n),
    .bus_we_n    (bus_we_n),
    .bus_drive   (bus_drive),
    .arr_we      (arr_we),
    .deselect    (deselect),
    .wr_protect  (wr_protect),
    .bat_sel     (bat_sel)
);

// File: tb/pfg_sram_front_tb.sv
`timescale 1ns/1ps
module pfg_sram_front_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ms_tick;
    logic [7:0]  rec_ms;
    logic        sup_hi_raw, sup_lo_raw, sup_bat_raw;
    logic        bus_ce_n, bus_oe_n, bus_we_n;
    logic [16:0] bus_addr;
    logic [7:0]  bus_din;
    logic [7:0]  bus_dout;
    logic        bus_drive;
    logic [16:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic        arr_we;
    logic [7:0]  arr_rdata;
    logic        deselect, wr_protect, bat_sel;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign arr_rdata = arr_addr[7:0] ^ 8'h5A;

    pfg_sram_front u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rec_ms(rec_ms),
        .sup_hi_raw(sup_hi_raw), .sup_lo_raw(sup_lo_raw), .sup_bat_raw(sup_bat_raw),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_drive(bus_drive), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_we(arr_we), .arr_rdata(arr_rdata), .deselect(deselect),
        .wr_protect(wr_protect), .bat_sel(bat_sel)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus(input logic ce, input logic oe, input logic we);
        bus_ce_n = ce; bus_oe_n = oe; bus_we_n = we;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            waitn(3);
        end
    endtask

    task automatic power_down();
        sup_lo_raw = 1'b0; sup_hi_raw = 1'b0;
        waitn(6);
    endtask

    // brings the supply up and checks release exactly at the limit-th tick
    task automatic power_up(input int limit, input string tag);
        sup_lo_raw = 1'b1; sup_hi_raw = 1'b1;
        waitn(6);
        check({tag, " held before ticks"}, deselect, 1);
        ticks(limit - 1);
        check({tag, " held at limit-1"}, deselect, 1);
        ticks(1);
        check({tag, " released at limit"}, deselect, 0);
        check({tag, " wr_protect released"}, wr_protect, 0);
    endtask

    task automatic t_reset();
        check("R11 deselect", deselect, 1);
        check("R11 wr_protect", wr_protect, 1);
        check("R11 bat_sel", bat_sel, 1);
        check("R11 bus_drive", bus_drive, 0);
        check("R11 arr_we", arr_we, 0);
    endtask

    task automatic t_blocked();
        bus(0, 1, 0);
        waitn(3);
        check("R4 no write while deselected", arr_we, 0);
        bus(0, 0, 1);
        waitn(2);
        check("R4 no drive while deselected", bus_drive, 0);
        check("R4 dout quiet while deselected", bus_dout, 0);
        bus(1, 1, 1);
        waitn(1);
    endtask

    task automatic t_bat();
        sup_bat_raw = 1'b1;
        waitn(2);
        check("R6 bat_sel after two edges", bat_sel, 1);
        waitn(1);
        check("R6 bat_sel after three edges", bat_sel, 0);
        sup_bat_raw = 1'b0;
        waitn(3);
        check("R6 bat_sel back on battery", bat_sel, 1);
        sup_bat_raw = 1'b1;
        waitn(3);
    endtask

    task automatic t_write();
        bus_addr = 17'h1ABCD; bus_din = 8'h3C;
        bus(0, 1, 0);
        waitn(1);
        check("R1 write strobe", arr_we, 1);
        check("R1 write addr", arr_addr, 17'h1ABCD);
        check("R1 write data", arr_wdata, 8'h3C);
        bus(0, 1, 1);
        waitn(1);
        check("R1 write ends on we rise", arr_we, 0);
        bus(1, 1, 0);
        bus_addr = 17'h00001; bus_din = 8'hFF;
        waitn(2);
        check("R1 we alone no write", arr_we, 0);
        bus(0, 1, 0);
        waitn(1);
        check("R1 ce-led write starts", arr_we, 1);
        check("R1 ce-led write data", arr_wdata, 8'hFF);
        bus(1, 1, 0);
        waitn(1);
        check("R1 ce-led write ends", arr_we, 0);
        bus(1, 1, 1);
        waitn(1);
    endtask

    task automatic t_read();
        bus_addr = 17'h12345;
        bus(0, 0, 1);
        waitn(1);
        check("R2 drive on read", bus_drive, 1);
        check("R2 read data", bus_dout, 8'h45 ^ 8'h5A);
        bus_addr = 17'h000A0;
        waitn(1);
        check("R2 read follows addr", bus_dout, 8'hA0 ^ 8'h5A);
        bus(0, 1, 1);
        waitn(1);
        check("R2 oe high no drive", bus_drive, 0);
        check("R2 oe high dout zero", bus_dout, 0);
        bus(1, 0, 1);
        waitn(1);
        check("R2 ce high no drive", bus_drive, 0);
        bus(1, 1, 1);
        waitn(1);
    endtask

    task automatic t_read_then_we();
        bus(0, 0, 1);
        waitn(2);
        check("R3 reading before we", bus_drive, 1);
        bus(0, 0, 0);
        waitn(1);
        check("R3 we low turns drive off", bus_drive, 0);
        check("R3 we low starts write", arr_we, 1);
        bus(1, 1, 1);
        waitn(1);
    endtask

    task automatic t_together();
        int seen = 0;
        bus(0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (bus_drive) seen++;
        end
        check("R3 simultaneous fall never drives", seen, 0);
        check("R3 simultaneous fall writes", arr_we, 1);
        bus(1, 1, 1);
        waitn(1);
    endtask

    task automatic t_hysteresis();
        sup_hi_raw = 1'b0;
        waitn(6);
        check("R12 upper drop only keeps select", deselect, 0);
        sup_hi_raw = 1'b1;
        waitn(2);
    endtask

    task automatic t_cutoff();
        int overlap = 0;
        int rise_at = -1;
        bus(0, 1, 0);
        waitn(2);
        check("R5 write running", arr_we, 1);
        sup_lo_raw = 1'b0; sup_hi_raw = 1'b0;
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            if (deselect && arr_we) overlap++;
            if (deselect && rise_at < 0) rise_at = i;
        end
        check("R5 no overlap of write and deselect", overlap, 0);
        check("R5 deselect on third edge", rise_at, 3);
        check("R4 wr_protect when down", wr_protect, 1);
        bus(1, 1, 1);
        waitn(2);
    endtask

    task automatic t_gate_after_release();
        bus(0, 1, 0);
        power_up(40, "R10 powerup");
        waitn(2);
        check("R10 held strobe not accepted", arr_we, 0);
        bus(1, 1, 0);
        waitn(1);
        bus(0, 1, 0);
        waitn(1);
        check("R10 accepted after ce high", arr_we, 1);
        bus(1, 1, 1);
        waitn(1);
    endtask

    task automatic t_restart();
        power_down();
        sup_lo_raw = 1'b1; sup_hi_raw = 1'b1;
        waitn(6);
        ticks(20);
        sup_hi_raw = 1'b0;
        waitn(6);
        check("R8 still deselected during dip", deselect, 1);
        sup_hi_raw = 1'b1;
        waitn(6);
        ticks(39);
        check("R8 count restarted", deselect, 1);
        ticks(1);
        check("R8 release after full count", deselect, 0);
    endtask

    task automatic t_clamp();
        power_down();
        rec_ms = 8'd5;
        power_up(40, "R9 low clamp");
        power_down();
        rec_ms = 8'd250;
        power_up(200, "R9 high clamp");
        power_down();
        rec_ms = 8'd60;
        power_up(60, "R9 in range");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                finish_run();
            end
        end
    end

    initial begin
        rst_n = 1'b0; ms_tick = 1'b0; rec_ms = 8'd40;
        sup_hi_raw = 1'b0; sup_lo_raw = 1'b0; sup_bat_raw = 1'b0;
        bus(1, 1, 1);
        bus_addr = '0; bus_din = '0;
        waitn(5);
        rst_n = 1'b1;
        waitn(1);
        t_reset();
        t_blocked();
        t_bat();
        power_up(40, "R7 basic");
        t_write();
        t_read();
        t_read_then_we();
        t_together();
        t_hysteresis();
        t_cutoff();
        t_gate_after_release();
        t_restart();
        t_clamp();
        finish_run();
    end

endmodule